// File: doc/BRIEF.md
# Multi-Bus Result Broadcast Arbiter

This block decides, every clock cycle, which finished results get onto the common data buses of an out-of-order core. Six classes of functional units can ask for a bus: branch, divide, load/store, multiply, floating-point add and integer ALU. The number of buses is a parameter. Up to that many requesters win in a cycle, chosen by a fixed ranking that puts branch first and integer ALU last. Branch outcomes use the same buses, so branches compete in the same arbitration.

Each winner is told which bus it got. Its tag and value then appear on that bus in the same cycle. Buses are handed out in ranking order: the best-ranked winner takes bus 0, the next one bus 1, and so on. A per-bus valid flag marks which buses carry a result. A free-running counter per bus records how many broadcasts that bus has made, so bus utilisation can be measured. The grant and the bus contents are combinational from the requests. Only the counters hold state.

Top module: `result_bus_arbiter`

## Requirements
- R1: In each cycle out of reset, the number of grants equals the smaller of the number of active requests and NUM_BUS.
- R2: Request and grant bit positions are fixed by class: bit 0 branch, 1 divide, 2 load/store, 3 multiply, 4 floating-point add, 5 integer ALU. A lower bit always ranks higher. A class is granted only if every requesting class with a lower bit is also granted.
- R3: A granted class's bus-index field (BIDX_W bits at position class*BIDX_W of `gnt_bus_o`) equals the number of granted classes that rank above it, so the best-ranked winner takes bus 0. The field of a class that is not granted reads zero.
- R4: `bus_vld_o[b]` is high exactly when b is less than the number of grants in that cycle.
- R5: On every valid bus b, the tag and data slices at position b equal the payload of the class that was given bus b.
- R6: A class that is not requesting is never granted.
- R7: Each bus counter rises by exactly one on every clock edge at which its bus is valid, and holds otherwise.
- R8: While reset is high, no grant is made, no bus is valid, and the counters are cleared to zero on the clock edge.
- R9: A request that loses arbitration and is held is granted in the first cycle in which fewer than NUM_BUS higher-ranked requests are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Per-class result request |
| req_tag_i | input | 6*TAG_W | Per-class destination tag, class c at slice c |
| req_data_i | input | 6*DATA_W | Per-class result value, class c at slice c |
| gnt_o | output | 6 | Per-class grant |
| gnt_bus_o | output | 6*BIDX_W | Bus index given to each class |
| bus_vld_o | output | NUM_BUS | Bus carries a result this cycle |
| bus_tag_o | output | NUM_BUS*TAG_W | Tag driven on each bus |
| bus_data_o | output | NUM_BUS*DATA_W | Value driven on each bus |
| bus_cnt_o | output | NUM_BUS*CNT_W | Broadcast count of each bus |

## Verification
The assertions assume that a functional unit which loses arbitration keeps its request high and its tag and value unchanged until it wins. They also assume that no request is pending at the edge where reset falls. The bench driver tracks every request that has lost. On each new cycle it raises that request again and replays the stored payload, whatever new traffic is chosen. It also clears all requests one cycle before it releases reset. Within those limits, both directed patterns and random request mixes are used, so that priority, bus packing and the hold-until-granted behaviour are all exercised.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

    localparam int unsigned NUM_CLASS = 6;
    localparam int unsigned SLOT_W    = 3;

    // Request bit position of each functional-unit class; lower ranks higher.
    typedef enum logic [2:0] {
        CLS_BRANCH = 3'd0,
        CLS_DIVIDE = 3'd1,
        CLS_LDST   = 3'd2,
        CLS_MULT   = 3'd3,
        CLS_FPADD  = 3'd4,
        CLS_INTALU = 3'd5
    } fu_class_e;

    // Grant decision for one class: won, and which bus slot.
    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } grant_t;

    // Number of set bits strictly below position pos.
    function automatic logic [SLOT_W:0] ones_below(
        input logic [NUM_CLASS-1:0] vec,
        input int unsigned          pos
    );
        logic [SLOT_W:0] n;
        n = '0;
        for (int unsigned i = 0; i < NUM_CLASS; i++) begin
            if (i < pos && vec[i]) n = n + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/rbus_grant.sv
module rbus_grant
    import rbus_pkg::*;
#(
    parameter int unsigned NUM_BUS = 2
) (
    input  logic                 rst,
    input  logic [NUM_CLASS-1:0] req,
    output grant_t [NUM_CLASS-1:0] gnt
);

    localparam int unsigned LAST_CLASS = int'(CLS_INTALU);

    always_comb begin
        for (int unsigned c = 0; c <= LAST_CLASS; c++) begin
            logic [SLOT_W:0] ahead;
            ahead       = ones_below(req, c);
            gnt[c].hit  = !rst && req[c] && (int'(ahead) < int'(NUM_BUS));
            gnt[c].slot = gnt[c].hit ? ahead[SLOT_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/rbus_steer.sv
module rbus_steer
    import rbus_pkg::*;
#(
    parameter int unsigned NUM_BUS = 2,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  grant_t [NUM_CLASS-1:0]               gnt,
    input  logic [NUM_CLASS-1:0][TAG_W-1:0]      tag_in,
    input  logic [NUM_CLASS-1:0][DATA_W-1:0]     data_in,
    output logic [NUM_BUS-1:0]                   vld,
    output logic [NUM_BUS-1:0][TAG_W-1:0]        tag_out,
    output logic [NUM_BUS-1:0][DATA_W-1:0]       data_out
);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic [NUM_CLASS-1:0] pick;

        always_comb begin
            for (int unsigned c = 0; c < NUM_CLASS; c++) begin
                pick[c] = gnt[c].hit && (int'(gnt[c].slot) == b);
            end
        end

        always_comb begin
            tag_out[b]  = '0;
            data_out[b] = '0;
            for (int unsigned c = 0; c < NUM_CLASS; c++) begin
                if (pick[c]) begin
                    tag_out[b]  = tag_out[b]  | tag_in[c];
                    data_out[b] = data_out[b] | data_in[c];
                end
            end
        end

        assign vld[b] = |pick;

        AST_BUS_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
            $onehot0(pick)); // R3

        if (b > 0) begin : g_prefix
            AST_VALID_PACKED: assert property (@(posedge clk) disable iff (rst)
                vld[b] |-> vld[b-1]); // R4
        end
    end

endmodule

// File: rtl/rbus_util_cnt.sv
module rbus_util_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (hit) cnt <= cnt + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        hit |=> cnt == $past(cnt) + 1'b1); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cnt)); // R7

endmodule

// File: rtl/result_bus_arbiter.sv
module result_bus_arbiter
    import rbus_pkg::*;
#(
    parameter int unsigned NUM_BUS = 2,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned BIDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CLASS-1:0]          req_i,
    input  logic [NUM_CLASS*TAG_W-1:0]    req_tag_i,
    input  logic [NUM_CLASS*DATA_W-1:0]   req_data_i,
    output logic [NUM_CLASS-1:0]          gnt_o,
    output logic [NUM_CLASS*BIDX_W-1:0]   gnt_bus_o,
    output logic [NUM_BUS-1:0]            bus_vld_o,
    output logic [NUM_BUS*TAG_W-1:0]      bus_tag_o,
    output logic [NUM_BUS*DATA_W-1:0]     bus_data_o,
    output logic [NUM_BUS*CNT_W-1:0]      bus_cnt_o
);

    grant_t [NUM_CLASS-1:0]             gnt;
    logic [NUM_CLASS-1:0][TAG_W-1:0]    tag_a;
    logic [NUM_CLASS-1:0][DATA_W-1:0]   data_a;
    logic [NUM_BUS-1:0][TAG_W-1:0]      btag;
    logic [NUM_BUS-1:0][DATA_W-1:0]     bdata;

    assign tag_a  = req_tag_i;
    assign data_a = req_data_i;

    rbus_grant #(.NUM_BUS(NUM_BUS)) u_grant (
        .rst (rst),
        .req (req_i),
        .gnt (gnt)
    );

    rbus_steer #(.NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .gnt      (gnt),
        .tag_in   (tag_a),
        .data_in  (data_a),
        .vld      (bus_vld_o),
        .tag_out  (btag),
        .data_out (bdata)
    );

    assign bus_tag_o  = btag;
    assign bus_data_o = bdata;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        assign gnt_o[c] = gnt[c].hit;
        assign gnt_bus_o[c*BIDX_W +: BIDX_W] = BIDX_W'(gnt[c].slot);

        AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
            (req_i[c] && !gnt_o[c]) |=> (req_i[c]
                && $stable(req_tag_i[c*TAG_W +: TAG_W])
                && $stable(req_data_i[c*DATA_W +: DATA_W]))); // R9

        AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (rst)
            gnt_o[c] |-> req_i[c]); // R6

        if (c > 0) begin : g_rank
            AST_PRIORITY_ORDER: assert property (@(posedge clk) disable iff (rst)
                gnt_o[c] |-> ((req_i[c-1:0] & ~gnt_o[c-1:0]) == '0)); // R2
        end
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_cnt
        rbus_util_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .hit (bus_vld_o[b]),
            .cnt (bus_cnt_o[b*CNT_W +: CNT_W])
        );
    end

    AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt_o) == (($countones(req_i) < NUM_BUS) ? $countones(req_i) : NUM_BUS)); // R1

    AST_VALID_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(bus_vld_o) == $countones(gnt_o)); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (gnt_o == '0 && bus_vld_o == '0)); // R8

endmodule

// File: tb/sim_result_bus_arbiter.sv
`timescale 1ns/1ps
module sim_result_bus_arbiter;

    localparam int NB = 3;
    localparam int TW = 6;
    localparam int DW = 16;
    localparam int CW = 12;
    localparam int BW = 2;
    localparam int NC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0]         req = '0;
    logic [NC-1:0][TW-1:0] tags = '0;
    logic [NC-1:0][DW-1:0] datas = '0;
    logic [NC-1:0]         gnt;
    logic [NC*BW-1:0]      gbus;
    logic [NB-1:0]         vld;
    logic [NB*TW-1:0]      btag;
    logic [NB*DW-1:0]      bdat;
    logic [NB*CW-1:0]      bcnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    result_bus_arbiter #(.NUM_BUS(NB), .TAG_W(TW), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .req_tag_i(tags), .req_data_i(datas),
        .gnt_o(gnt), .gnt_bus_o(gbus), .bus_vld_o(vld), .bus_tag_o(btag),
        .bus_data_o(bdat), .bus_cnt_o(bcnt)
    );

    typedef struct {
        logic [NC-1:0]    g;
        logic [NC*BW-1:0] gb;
        logic [NB-1:0]    v;
        logic [NB*TW-1:0] t;
        logic [NB*DW-1:0] d;
    } exp_t;

    exp_t q[$];
    logic [NC-1:0] pending = '0;
    int exp_cnt [NB];

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Driver: one cycle of requests; lost requests are replayed unchanged.
    task automatic drive(input logic [NC-1:0] fresh);
        exp_t e;
        int slot;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            if (pending[c]) begin
                req[c] = 1'b1;
            end else begin
                req[c]   = fresh[c];
                tags[c]  = TW'($urandom);
                datas[c] = DW'($urandom);
            end
        end
        e.g = '0; e.gb = '0; e.v = '0; e.t = '0; e.d = '0;
        slot = 0;
        for (int c = 0; c < NC; c++) begin
            if (req[c] && slot < NB) begin
                e.g[c] = 1'b1;
                e.gb[c*BW +: BW] = BW'(slot);
                e.v[slot] = 1'b1;
                e.t[slot*TW +: TW] = tags[c];
                e.d[slot*DW +: DW] = datas[c];
                slot++;
            end
            pending[c] = req[c] && !e.g[c];
        end
        q.push_back(e);
    endtask

    // Monitor: compares each cycle's outputs with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R1/R2 grant vector", 64'(gnt), 64'(e.g));
                chk("R6 grant without request", 64'(gnt & ~req), 64'(0));
                chk("R3 bus index", 64'(gbus), 64'(e.gb));
                chk("R4 bus valid", 64'(vld), 64'(e.v));
                for (int b = 0; b < NB; b++) begin
                    if (e.v[b]) begin
                        chk("R5 bus tag", 64'(btag[b*TW +: TW]), 64'(e.t[b*TW +: TW]));
                        chk("R5 bus data", 64'(bdat[b*DW +: DW]), 64'(e.d[b*DW +: DW]));
                    end
                    chk("R7 bus counter", 64'(bcnt[b*CW +: CW]), 64'(exp_cnt[b]));
                    if (e.v[b]) exp_cnt[b]++;
                end
            end
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
        // Reset phase: requests present but nothing may be granted.
        req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        chk("R8 no grant in reset", 64'(gnt), 64'(0));
        chk("R8 no valid in reset", 64'(vld), 64'(0));
        chk("R8 counters cleared", 64'(bcnt), 64'(0));
        req = '0;
        @(negedge clk);
        rst = 1'b0;

        drive(6'b000000);
        drive(6'b100000);
        drive(6'b101000);
        drive(6'b111111);
        drive(6'b000000);
        #2;
        chk("R9 held losers granted", 64'(gnt), 64'(6'b111000));
        drive(6'b010110);
        drive(6'b000001);
        drive(6'b111110);
        drive(6'b000000);
        drive(6'b000000);
        for (int i = 0; i < 300; i++) drive(NC'($urandom));
        for (int i = 0; i < 4; i++) drive(6'b000000);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule